// File: doc/BRIEF.md
# Fractional Clock-Enable Gater with Deferred Kick Update

The block turns a free-running clock into one or more clock-enable streams. Each stream passes a programmable fraction `m/32` of the input cycles, and that rate can then be divided further by a fixed per-channel post-divider. Software sets each channel's rate through a 5-bit field. The multiplier is encoded as `m = 32 - field`, so a field of 0 gives the full rate. Each field can be placed either in a dedicated frequency-control register or in the update register, next to the kick bit. Both the placement and the bit offset are set by parameter.

A field write by itself changes nothing at the outputs. Software sets the kick bit to request the change. The block then waits for the next boundary of its 32-cycle enable frame, copies every field into the active ratio registers, and clears the kick bit by itself. Software polls the kick bit until it reads 0. While a kick is pending, the divider fields are write-protected, so a late write cannot corrupt the update in flight.

Top module: `frac_clk_gater`

## Requirements
- R1: After reset both registers read 0 (every field 0, kick 0), and channel 0 (post-divider 1) asserts its enable in every cycle.
- R2: A channel with post-divider 1 and active field f asserts its enable in exactly 32-f cycles of any 32 consecutive cycles.
- R3: Field value 0 gives an enable in every cycle (32/32). Field value 31 gives exactly one enable per 32 cycles.
- R4: A channel with post-divider d passes one of every d gated pulses, so it asserts exactly 32-f enables in any 32*d consecutive cycles (channel 1 default d=3).
- R5: A field write with no kick leaves the enable output unchanged. The old ratio stays in effect.
- R6: The kick bit is bit 31 of the update register (select 1). Writing 1 there with byte enable 3 sets it, and it reads back 1 until the new ratios are applied.
- R7: The kick bit clears itself at the next 32-cycle frame boundary, no later than 64 cycles after it was set. When it reads 0, the new ratios are in effect.
- R8: While kick is pending, writes to the divider field bits are ignored. Readback keeps the value that was present when kick was set, and that value is the ratio applied.
- R9: Writes honour per-byte enables. Bytes not enabled keep their contents, and every non-kick bit reads back as last written.
- R10: Channel 0's field is at bits 4:0 of the control register (select 0). Channel 1's field is at bits 12:8 of the update register (select 1). A single write to the update register may set channel 1's field and the kick bit together, and that field is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being gated |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control register, 1 update register |
| wr_be | input | 4 | Byte enables for the write |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 control register, 1 update register |
| rd_data | output | 32 | Read data for the selected register (combinational) |
| clk_en | output | NUM_CH | Per-channel clock-enable streams |

## Verification
Suppose an active ratio or phase accumulator holds a wrong value. The enable count in any 32-cycle window then differs from 32-f right away; for a post-divided channel the error shows within 32*d cycles. A kick flag that sticks, or a frame counter that drifts, shows at the ports as a kick bit that stays 1 past 64 polls. A missing write-protect shows as a changed field readback while kick is still set, and then as the wrong enable count once the update lands. A byte-enable fault shows as a corrupted readback in the very next read.

// File: rtl/frac_gater_pkg.sv
package frac_gater_pkg;

    localparam int FW       = 5;
    localparam int MW       = FW + 1;
    localparam int FRAME    = 1 << FW;
    localparam int KICK_BIT = 31;

    typedef logic [FW-1:0] field_t;
    typedef logic [MW-1:0] mult_t;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_UPD  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic        en;
        reg_sel_e    sel;
        logic [3:0]  be;
        logic [31:0] data;
    } reg_wr_t;

    function automatic mult_t field_to_mult(field_t f);
        return mult_t'(FRAME) - mult_t'(f);
    endfunction

    function automatic logic [31:0] be_to_mask(logic [3:0] be);
        logic [31:0] m;
        for (int i = 0; i < 4; i++) begin
            m[8*i +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/gater_regs.sv
module gater_regs
    import frac_gater_pkg::*;
#(
    parameter int                  NUM_CH     = 2,
    parameter logic [NUM_CH*8-1:0] FLD_POS    = {8'd8, 8'd0},
    parameter logic [NUM_CH-1:0]   FLD_IN_UPD = 2'b10
) (
    input  logic        clk,
    input  logic        rst,
    input  reg_wr_t     wr,
    input  logic        load,
    output logic [31:0] ctrl_q,
    output logic [30:0] upd_q,
    output logic        kick_q
);

    logic [31:0] ctrl_prot;
    logic [31:0] upd_prot;
    logic [31:0] wmask;
    logic        kick_set;

    always_comb begin
        ctrl_prot = '0;
        upd_prot  = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (FLD_IN_UPD[ch]) begin
                upd_prot[int'(FLD_POS[ch*8 +: 8]) +: FW] = '1;
            end else begin
                ctrl_prot[int'(FLD_POS[ch*8 +: 8]) +: FW] = '1;
            end
        end
    end

    always_comb begin
        wmask = be_to_mask(wr.be);
        if (kick_q) begin
            wmask = wmask & ~((wr.sel == SEL_UPD) ? upd_prot : ctrl_prot);
        end
    end

    assign kick_set = wr.en && (wr.sel == SEL_UPD) && wr.be[3] && wr.data[KICK_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            upd_q  <= '0;
            kick_q <= 1'b0;
        end else begin
            if (wr.en && wr.sel == SEL_CTRL) begin
                ctrl_q <= (ctrl_q & ~wmask) | (wr.data & wmask);
            end
            if (wr.en && wr.sel == SEL_UPD) begin
                upd_q <= (upd_q & ~wmask[30:0]) | (wr.data[30:0] & wmask[30:0]);
            end
            if (load) begin
                kick_q <= 1'b0;
            end else if (kick_set) begin
                kick_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ratio_gen.sv
module ratio_gen
    import frac_gater_pkg::*;
#(
    parameter int POST_DIV = 1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  field_t field,
    output mult_t  mult,
    output logic   en
);

    localparam int CW = (POST_DIV > 1) ? $clog2(POST_DIV) : 1;

    logic [FW-1:0] acc_q;
    logic [MW-1:0] sum;
    logic          raw;

    assign sum = {1'b0, acc_q} + mult;
    assign raw = sum[FW];

    always_ff @(posedge clk) begin
        if (rst) begin
            mult  <= mult_t'(FRAME);
            acc_q <= '0;
        end else if (load) begin
            mult  <= field_to_mult(field);
            acc_q <= '0;
        end else begin
            acc_q <= sum[FW-1:0];
        end
    end

    generate
        if (POST_DIV > 1) begin : g_post
            logic [CW-1:0] cnt_q;
            always_ff @(posedge clk) begin
                if (rst || load) begin
                    cnt_q <= '0;
                end else if (raw) begin
                    cnt_q <= (cnt_q == CW'(POST_DIV - 1)) ? '0 : cnt_q + 1'b1;
                end
            end
            assign en = raw && (cnt_q == '0);
        end else begin : g_direct
            assign en = raw;
        end
    endgenerate

endmodule

// File: rtl/frac_clk_gater.sv
module frac_clk_gater
    import frac_gater_pkg::*;
#(
    parameter int                  NUM_CH     = 2,
    parameter logic [NUM_CH*8-1:0] FLD_POS    = {8'd8, 8'd0},
    parameter logic [NUM_CH-1:0]   FLD_IN_UPD = 2'b10,
    parameter logic [NUM_CH*8-1:0] POST_DIV   = {8'd3, 8'd1}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [3:0]        wr_be,
    input  logic [31:0]       wr_data,
    input  logic              rd_sel,
    output logic [31:0]       rd_data,
    output logic [NUM_CH-1:0] clk_en
);

    reg_wr_t              wr;
    logic [31:0]          ctrl_q;
    logic [30:0]          upd_q;
    logic                 kick_q;
    logic [FW-1:0]        frame_q;
    logic                 load;
    logic [NUM_CH*FW-1:0] field_bus;
    logic [NUM_CH*MW-1:0] mult_bus;

    assign wr = '{en: wr_en, sel: reg_sel_e'(wr_sel), be: wr_be, data: wr_data};

    always_ff @(posedge clk) begin
        if (rst) frame_q <= '0;
        else     frame_q <= frame_q + 1'b1;
    end

    assign load = kick_q && (frame_q == FW'(FRAME - 1));

    gater_regs #(
        .NUM_CH(NUM_CH), .FLD_POS(FLD_POS), .FLD_IN_UPD(FLD_IN_UPD)
    ) i_regs (
        .clk(clk), .rst(rst), .wr(wr), .load(load),
        .ctrl_q(ctrl_q), .upd_q(upd_q), .kick_q(kick_q)
    );

    genvar ch;
    generate
        for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
            localparam int POS = int'(FLD_POS[ch*8 +: 8]);
            if (FLD_IN_UPD[ch]) begin : g_upd
                assign field_bus[ch*FW +: FW] = upd_q[POS +: FW];
            end else begin : g_ctrl
                assign field_bus[ch*FW +: FW] = ctrl_q[POS +: FW];
            end
            ratio_gen #(.POST_DIV(int'(POST_DIV[ch*8 +: 8]))) i_gen (
                .clk(clk), .rst(rst), .load(load),
                .field(field_bus[ch*FW +: FW]),
                .mult(mult_bus[ch*MW +: MW]),
                .en(clk_en[ch])
            );
        end
    endgenerate

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_UPD: rd_data = {kick_q, upd_q};
            default: rd_data = ctrl_q;
        endcase
    end

endmodule

// File: rtl/frac_clk_gater_chk.sv
module frac_clk_gater_chk
    import frac_gater_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 kick_q,
    input logic [FW-1:0]        frame_q,
    input logic                 load,
    input logic [NUM_CH*FW-1:0] field_bus,
    input logic [NUM_CH*MW-1:0] mult_bus
);

    logic [6:0] pend_cnt;

    always_ff @(posedge clk) begin
        if (rst || !kick_q) pend_cnt <= '0;
        else                pend_cnt <= pend_cnt + 1'b1;
    end

    // R7: pending time stays inside the 64-cycle window
    a_r7_kick_bounded: assert property (@(posedge clk) disable iff (rst)
        pend_cnt < 7'd64);

    // R7: the kick bit drops only as a new frame begins
    a_r7_clear_at_frame: assert property (@(posedge clk) disable iff (rst)
        $fell(kick_q) |-> frame_q == '0);

    // R8: fields frozen while a kick is pending
    a_r8_field_frozen: assert property (@(posedge clk) disable iff (rst)
        (kick_q && $past(kick_q)) |-> $stable(field_bus));

    // R5: active ratios change only at an applied update
    a_r5_ratio_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(load) |-> $stable(mult_bus));

    // R1: no kick pending and frame at zero straight after reset
    a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!kick_q && frame_q == '0));

    // R2: every active multiplier in 1..32
    always_comb begin
        if (!rst) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                a_r2_mult_range: assert (mult_bus[ch*MW +: MW] >= MW'(1) &&
                                         mult_bus[ch*MW +: MW] <= MW'(FRAME));
            end
        end
    end

endmodule

bind frac_clk_gater frac_clk_gater_chk #(.NUM_CH(NUM_CH)) i_chk (
    .clk(clk), .rst(rst), .kick_q(kick_q), .frame_q(frame_q),
    .load(load), .field_bus(field_bus), .mult_bus(mult_bus)
);

// File: tb/test_frac_clk_gater.sv
module test_frac_clk_gater;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic [1:0]  clk_en;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    frac_clk_gater i_frac_clk_gater (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_be(wr_be),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .clk_en(clk_en)
    );

    // {ch1 field, ch0 field}
    localparam int NV = 5;
    localparam logic [9:0] VEC [NV] = '{
        {5'd0,  5'd8},
        {5'd31, 5'd31},
        {5'd16, 5'd0},
        {5'd5,  5'd20},
        {5'd1,  5'd12}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [3:0] be, input logic [31:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_be = be; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_be = '0;
    endtask

    task automatic rd_reg(input logic sel, output logic [31:0] d);
        rd_sel = sel;
        #1;
        d = rd_data;
    endtask

    task automatic wait_kick(output int cyc);
        logic [31:0] v;
        cyc = 0;
        rd_reg(1'b1, v);
        while (v[31] && cyc < 200) begin
            @(negedge clk);
            cyc++;
            rd_reg(1'b1, v);
        end
    endtask

    task automatic count_en(input int n, output int c0, output int c1);
        c0 = 0; c1 = 0;
        for (int i = 0; i < n; i++) begin
            c0 += int'(clk_en[0]);
            c1 += int'(clk_en[1]);
            @(negedge clk);
        end
    endtask

    initial begin
        logic [31:0] v;
        int c0, c1, cyc, prev0;

        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(1'b0, v); check(v == 32'h0, "R1 ctrl reset", int'(v), 0);
        rd_reg(1'b1, v); check(v == 32'h0, "R1 upd reset", int'(v), 0);
        count_en(32, c0, c1);
        check(c0 == 32, "R1 ch0 full rate", c0, 32);

        prev0 = 32;
        for (int k = 0; k < NV; k++) begin
            int f0, f1;
            f0 = int'(VEC[k][4:0]);
            f1 = int'(VEC[k][9:5]);
            wr_reg(1'b0, 4'b0001, 32'(f0));
            count_en(32, c0, c1);
            check(c0 == prev0, "R5 deferred write", c0, prev0);
            // R10: ch1 field and kick in one write
            wr_reg(1'b1, 4'b1010, 32'h8000_0000 | (32'(f1) << 8));
            rd_reg(1'b1, v);
            check(v[31] == 1'b1, "R6 kick reads set", int'(v[31]), 1);
            wait_kick(cyc);
            check(cyc <= 64, "R7 kick self-clears", cyc, 64);
            count_en(96, c0, c1);
            check(c0 == 3 * (32 - f0), "R2 R3 ch0 count", c0, 3 * (32 - f0));
            check(c1 == 32 - f1, "R4 R10 ch1 post-div count", c1, 32 - f1);
            prev0 = 32 - f0;
        end

        // R8: field write while kick pending is ignored
        wr_reg(1'b0, 4'b0001, 32'd4);
        wr_reg(1'b1, 4'b1000, 32'h8000_0000);
        wr_reg(1'b0, 4'b0001, 32'd20);
        rd_reg(1'b0, v);
        check(v[4:0] == 5'd4, "R8 field protected", int'(v[4:0]), 4);
        wait_kick(cyc);
        check(cyc <= 64, "R7 kick clears after protect", cyc, 64);
        count_en(32, c0, c1);
        check(c0 == 28, "R8 applied ratio", c0, 28);

        // R9: byte enables preserve other bytes
        wr_reg(1'b0, 4'b1110, 32'hA5C3_7E1F);
        rd_reg(1'b0, v);
        check(v == 32'hA5C3_7E04, "R9 ctrl byte enables", int'(v), int'(32'hA5C3_7E04));
        wr_reg(1'b1, 4'b0100, 32'hFFAB_FFFF);
        rd_reg(1'b1, v);
        check(v == 32'h00AB_0100, "R9 upd byte enables", int'(v), int'(32'h00AB_0100));
        count_en(96, c0, c1);
        check(c0 == 84, "R5 ch0 unchanged", c0, 84);
        check(c1 == 31, "R5 ch1 unchanged", c1, 31);

        $display("%0d/%0d checks passed", checks - fails, checks);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule